// File: doc/BRIEF.md
# Power-Register Access Command Sequencer

This block reads, writes or read-modify-writes a batch of registers on a power-management device, reaching it through a memory-mapped mailbox. A single request names one of three operations, between one and five items, a list of 16-bit register addresses and a list of data bytes. The block packs them into a byte payload and writes it as whole 32-bit words into the mailbox write buffer. It then writes the command word and polls the mailbox status until busy clears or the poll budget runs out. For a read, it finally fetches the returned bytes from the mailbox read buffer.

Only one request is in flight at a time. A request is taken only while `req_ready` is high. Completion is marked by a one-cycle `done` pulse, which carries a two-bit result code and, for reads, the returned bytes. The mailbox offsets, the poll budget and the wait between polls are all parameters.

Top module: `prw_seq`

## Requirements
- R1: `req_ready` is 1 only while the sequencer is idle. A request is accepted only on a clock edge where both `req_valid` and `req_ready` are 1. `req_valid` asserted while the sequencer is busy is ignored: no second command is issued and no extra `done` pulse appears. There is no mailbox traffic while the sequencer is idle.
- R2: A request is rejected when its count is 0, its count is greater than MAX_ITEMS, or its operation code is 3. A rejected request generates no mailbox access, and `done` rises on the cycle after acceptance with result 3.
- R3: Item i's 16-bit address occupies payload bytes 2i (low byte) and 2i+1 (high byte), in list order. Payload byte k goes to bits [8(k mod 4)+7 : 8(k mod 4)] of write-buffer word k/4, and word j is written at offset WBUF_OFS+4j. Unused payload bytes are zero.
- R4: For operation code 0 (write), data byte i sits at payload byte 2·count+i. The size field is 3·count and the command id is 0.
- R5: For operation code 1 (read), the payload holds only the addresses. The size field is 2·count and the command id is 1.
- R6: For operation code 2 (read-modify-write), the payload is address item 0 (low byte, then high byte), then data byte 0 as the value, then data byte 1 as the mask. The size field is 4 and the command id is 2.
- R7: The sequencer writes exactly ceil(size/4) payload words and then one command word at CMD_OFS. The command word has the following fields:
  - bits [7:0] = 0xFF
  - bit 8 (interrupt-on-completion) = 0
  - bits [11:9] = 0
  - bits [15:12] = command id
  - bits [23:16] = size
  - bits [31:24] = 0
- R8: After the command, the sequencer reads the status register at STAT_OFS. While status bit 0 (busy) is 1 and the poll budget remains, it waits at least POLL_GAP cycles and reads status again. When busy reads 0 and bit 1 (error) reads 0, the result is 0 (ok).
- R9: When busy reads 0 but status bit 1 reads 1, the result is 1 (I/O error), and the read buffer is not accessed.
- R10: When all POLL_LIMIT status reads return busy, the result is 2 (timeout). Exactly POLL_LIMIT status reads are made.
- R11: On a successful read, the sequencer reads ceil(count/4) read-buffer words at RBUF_OFS+4j. Byte n of `rd_data` then equals read-buffer byte n (word n/4, bits 8(n mod 4) upward) for n < count; the other bytes are zero. In every other outcome, `rd_data` is all zero.
- R12: `done` is a one-cycle pulse. `result` and `rd_data` are valid while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 write, 1 read, 2 read-modify-write |
| req_count | input | CNT_W | Item count |
| req_addrs | input | 16*MAX_ITEMS | Address list, item i at bits [16i+15:16i] |
| req_data | input | 8*MAX_ITEMS | Data bytes, byte i at bits [8i+7:8i] |
| req_ready | output | 1 | Idle, request can be taken |
| done | output | 1 | Completion pulse |
| result | output | 2 | 0 ok, 1 I/O error, 2 timeout, 3 bad argument |
| rd_data | output | 8*MAX_ITEMS | Bytes returned by a read |
| mb_valid | output | 1 | Mailbox access strobe |
| mb_we | output | 1 | Mailbox access is a write |
| mb_addr | output | MB_AW | Mailbox byte offset |
| mb_wdata | output | 32 | Mailbox write word |
| mb_rdata | input | 32 | Mailbox read word, valid the cycle after the access is taken |

## Verification
The bench builds the sequencer with POLL_LIMIT of 6 and POLL_GAP of 3, and keeps the item limit at five. The short poll budget makes both sides of the timeout edge reachable in a few hundred cycles: five busy replies still end in success, while six end in a timeout. With the full item limit, a five-item write fills four payload words and a five-item read crosses into the second read-buffer word. A mailbox model in the bench records every payload word, command word and status read, and compares them with values rebuilt from the packing rules.

// File: rtl/prw_pkg.sv
package prw_pkg;
  localparam logic [7:0] MSG_PWR = 8'hFF;

  localparam logic [1:0] OP_WRITE = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_RMW   = 2'd2;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_IOERR   = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_BADARG  = 2'd3
  } res_e;
endpackage

// File: rtl/prw_packer.sv
module prw_packer
  import prw_pkg::*;
#(
  parameter int unsigned MAX_ITEMS = 5,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned PAY_BYTES = 4 * MAX_ITEMS
) (
  input  logic [1:0]               op,
  input  logic [CNT_W-1:0]         count,
  input  logic [16*MAX_ITEMS-1:0]  addrs,
  input  logic [8*MAX_ITEMS-1:0]   data,
  output logic                     ok,
  output logic [8*PAY_BYTES-1:0]   payload,
  output logic [7:0]               size,
  output logic [7:0]               nwords
);
  always_comb begin
    payload = '0;
    size    = '0;
    ok      = (count != '0) && (int'(count) <= int'(MAX_ITEMS)) && (op != 2'd3);
    if (ok) begin
      if (op == OP_RMW) begin
        payload[15:0]  = addrs[15:0];
        payload[23:16] = data[7:0];
        payload[31:24] = data[15:8];
        size = 8'd4;
      end else begin
        for (int i = 0; i < int'(MAX_ITEMS); i++) begin
          if (i < int'(count)) begin
            payload[16*i +: 16] = addrs[16*i +: 16];
          end
        end
        if (op == OP_WRITE) begin
          for (int i = 0; i < int'(MAX_ITEMS); i++) begin
            if (i < int'(count) && (2*int'(count) + i) < int'(PAY_BYTES)) begin
              payload[8*(2*int'(count) + i) +: 8] = data[8*i +: 8];
            end
          end
          size = 8'(3 * int'(count));
        end else begin
          size = 8'(2 * int'(count));
        end
      end
    end
    nwords = 8'((int'(size) + 3) / 4);
  end
endmodule

// File: rtl/prw_poll_ctr.sv
module prw_poll_ctr #(
  parameter int unsigned POLL_LIMIT = 100000,
  parameter int unsigned POLL_GAP   = 4,
  localparam int unsigned ATT_W = $clog2(POLL_LIMIT + 1),
  localparam int unsigned GAP_W = $clog2(POLL_GAP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bump,
  input  logic gap_load,
  output logic limit_hit,
  output logic gap_done
);
  logic [ATT_W-1:0] attempts;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)       attempts <= '0;
    else if (clr)  attempts <= '0;
    else if (bump) attempts <= attempts + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             gap <= '0;
    else if (gap_load)   gap <= GAP_W'(POLL_GAP);
    else if (gap != '0)  gap <= gap - 1'b1;
  end

  assign limit_hit = (attempts == ATT_W'(POLL_LIMIT));
  assign gap_done  = (gap == '0);

  assert_poll_bounded_R10: assert property (@(posedge clk) disable iff (rst)
    bump |-> !limit_hit)
    else $error("status read issued past the poll budget");

  assert_gap_counts_R8: assert property (@(posedge clk) disable iff (rst)
    (gap_load && !bump) |=> !gap_done)
    else $error("poll gap did not start");
endmodule

// File: rtl/prw_seq.sv
module prw_seq
  import prw_pkg::*;
#(
  parameter int unsigned MAX_ITEMS  = 5,
  parameter int unsigned POLL_LIMIT = 100000,
  parameter int unsigned POLL_GAP   = 4,
  parameter int unsigned MB_AW      = 8,
  parameter logic [MB_AW-1:0] CMD_OFS  = 8'h00,
  parameter logic [MB_AW-1:0] STAT_OFS = 8'h04,
  parameter logic [MB_AW-1:0] WBUF_OFS = 8'h80,
  parameter logic [MB_AW-1:0] RBUF_OFS = 8'h90,
  localparam int unsigned CNT_W     = $clog2(MAX_ITEMS + 3),
  localparam int unsigned PAY_BYTES = 4 * MAX_ITEMS,
  localparam int unsigned RD_WORDS  = (MAX_ITEMS + 3) / 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [1:0]               req_op,
  input  logic [CNT_W-1:0]         req_count,
  input  logic [16*MAX_ITEMS-1:0]  req_addrs,
  input  logic [8*MAX_ITEMS-1:0]   req_data,
  output logic                     req_ready,
  output logic                     done,
  output logic [1:0]               result,
  output logic [8*MAX_ITEMS-1:0]   rd_data,
  output logic                     mb_valid,
  output logic                     mb_we,
  output logic [MB_AW-1:0]         mb_addr,
  output logic [31:0]              mb_wdata,
  input  logic [31:0]              mb_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_WBUF, S_CMD, S_POLL, S_PWAIT, S_PCHK, S_GAP,
    S_RREQ, S_RWAIT, S_RCHK, S_RDONE
  } state_e;

  state_e                    state;
  logic [1:0]                op_q;
  logic [CNT_W-1:0]          cnt_q;
  logic [8*PAY_BYTES-1:0]    pay_q;
  logic [7:0]                size_q, nw_q, idx;
  logic [32*RD_WORDS-1:0]    rbuf;
  logic [8*MAX_ITEMS-1:0]    rd_sel;
  logic [7:0]                rd_words;
  logic [31:0]               cmd_word;

  logic                      pk_ok;
  logic [8*PAY_BYTES-1:0]    pk_payload;
  logic [7:0]                pk_size, pk_nwords;
  logic                      limit_hit, gap_done, pc_clr, pc_bump, pc_gap;

  prw_packer #(.MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W), .PAY_BYTES(PAY_BYTES)) u_pack (
    .op(req_op), .count(req_count), .addrs(req_addrs), .data(req_data),
    .ok(pk_ok), .payload(pk_payload), .size(pk_size), .nwords(pk_nwords)
  );

  assign pc_clr  = (state == S_CMD);
  assign pc_bump = (state == S_POLL);
  assign pc_gap  = (state == S_PCHK) && mb_rdata[0] && !limit_hit;

  prw_poll_ctr #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_poll (
    .clk(clk), .rst(rst), .clr(pc_clr), .bump(pc_bump), .gap_load(pc_gap),
    .limit_hit(limit_hit), .gap_done(gap_done)
  );

  assign req_ready = (state == S_IDLE);
  assign cmd_word  = {8'h00, size_q, 2'b00, op_q, 3'b000, 1'b0, MSG_PWR};
  assign rd_words  = 8'((int'(cnt_q) + 3) / 4);

  always_comb begin
    rd_sel = '0;
    for (int n = 0; n < int'(MAX_ITEMS); n++) begin
      if (n < int'(cnt_q)) rd_sel[8*n +: 8] = rbuf[8*n +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= '0;
      cnt_q    <= '0;
      pay_q    <= '0;
      size_q   <= '0;
      nw_q     <= '0;
      idx      <= '0;
      rbuf     <= '0;
      done     <= 1'b0;
      result   <= RES_OK;
      rd_data  <= '0;
      mb_valid <= 1'b0;
      mb_we    <= 1'b0;
      mb_addr  <= '0;
      mb_wdata <= '0;
    end else begin
      done     <= 1'b0;
      mb_valid <= 1'b0;
      mb_we    <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          if (!pk_ok) begin
            done    <= 1'b1;
            result  <= RES_BADARG;
            rd_data <= '0;
          end else begin
            op_q   <= req_op;
            cnt_q  <= req_count;
            pay_q  <= pk_payload;
            size_q <= pk_size;
            nw_q   <= pk_nwords;
            idx    <= '0;
            rbuf   <= '0;
            state  <= S_WBUF;
          end
        end
        S_WBUF: begin
          mb_valid <= 1'b1;
          mb_we    <= 1'b1;
          mb_addr  <= WBUF_OFS + MB_AW'(4 * int'(idx));
          mb_wdata <= pay_q[32*int'(idx) +: 32];
          if (idx == nw_q - 8'd1) begin
            idx   <= '0;
            state <= S_CMD;
          end else begin
            idx <= idx + 8'd1;
          end
        end
        S_CMD: begin
          mb_valid <= 1'b1;
          mb_we    <= 1'b1;
          mb_addr  <= CMD_OFS;
          mb_wdata <= cmd_word;
          state    <= S_POLL;
        end
        S_POLL: begin
          mb_valid <= 1'b1;
          mb_addr  <= STAT_OFS;
          state    <= S_PWAIT;
        end
        S_PWAIT: state <= S_PCHK;
        S_PCHK: begin
          if (mb_rdata[0]) begin
            if (limit_hit) begin
              done    <= 1'b1;
              result  <= RES_TIMEOUT;
              rd_data <= '0;
              state   <= S_IDLE;
            end else begin
              state <= S_GAP;
            end
          end else if (mb_rdata[1]) begin
            done    <= 1'b1;
            result  <= RES_IOERR;
            rd_data <= '0;
            state   <= S_IDLE;
          end else if (op_q == OP_READ) begin
            idx   <= '0;
            state <= S_RREQ;
          end else begin
            done    <= 1'b1;
            result  <= RES_OK;
            rd_data <= '0;
            state   <= S_IDLE;
          end
        end
        S_GAP: if (gap_done) state <= S_POLL;
        S_RREQ: begin
          mb_valid <= 1'b1;
          mb_addr  <= RBUF_OFS + MB_AW'(4 * int'(idx));
          state    <= S_RWAIT;
        end
        S_RWAIT: state <= S_RCHK;
        S_RCHK: begin
          rbuf[32*int'(idx) +: 32] <= mb_rdata;
          if (idx == rd_words - 8'd1) begin
            state <= S_RDONE;
          end else begin
            idx   <= idx + 8'd1;
            state <= S_RREQ;
          end
        end
        S_RDONE: begin
          done    <= 1'b1;
          result  <= RES_OK;
          rd_data <= rd_sel;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    mb_valid |-> !req_ready)
    else $error("mailbox access while idle");

  assert_badarg_R2: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !pk_ok) |=> (done && result == RES_BADARG && !mb_valid))
    else $error("bad request not rejected");

  assert_cmd_fields_R7: assert property (@(posedge clk) disable iff (rst)
    (mb_valid && mb_we && mb_addr == CMD_OFS) |->
      (mb_wdata[7:0] == MSG_PWR && mb_wdata[11:8] == 4'h0 && mb_wdata[31:24] == 8'h00))
    else $error("command word malformed");

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done held longer than one cycle");

  assert_rd_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (done && result != RES_OK) |-> (rd_data == '0))
    else $error("read data not cleared on failure");
endmodule

// File: tb/prw_seq_tb.sv
`timescale 1ns/1ps
module prw_seq_tb;
  localparam int MAXI = 5;
  localparam logic [31:0] RB0 = 32'h44332211;
  localparam logic [31:0] RB1 = 32'h88776655;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  cnt;
    logic [79:0] adr;
    logic [39:0] dat;
    logic [7:0]  busy;
    logic        err;
    logic [1:0]  res;
    logic [31:0] cmd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd2, 80'h0000_0000_0000_00A5_1234, 40'h00_0000_C35A, 8'd2, 1'b0, 2'd0, 32'h000600FF},
    '{2'd1, 3'd3, 80'h0000_0000_0320_0011_0010, 40'h00_0000_0000, 8'd0, 1'b0, 2'd0, 32'h000610FF},
    '{2'd2, 3'd1, 80'h0000_0000_0000_0000_00F0, 40'h00_0000_0F81, 8'd1, 1'b0, 2'd0, 32'h000420FF},
    '{2'd0, 3'd5, 80'h0005_0004_0003_0002_0001, 40'h55_4433_2211, 8'd5, 1'b0, 2'd0, 32'h000F00FF},
    '{2'd1, 3'd5, 80'h0105_0104_0103_0102_0101, 40'h00_0000_0000, 8'd0, 1'b0, 2'd0, 32'h000A10FF},
    '{2'd1, 3'd2, 80'h0000_0000_0000_0041_0040, 40'h00_0000_0000, 8'd6, 1'b0, 2'd2, 32'h000410FF},
    '{2'd0, 3'd1, 80'h0000_0000_0000_0000_0077, 40'h00_0000_00AB, 8'd1, 1'b1, 2'd1, 32'h000300FF},
    '{2'd1, 3'd1, 80'h0000_0000_0000_0000_0078, 40'h00_0000_0000, 8'd0, 1'b1, 2'd1, 32'h000210FF},
    '{2'd0, 3'd0, 80'h0000_0000_0000_0000_0001, 40'h00_0000_0001, 8'd0, 1'b0, 2'd3, 32'h0},
    '{2'd1, 3'd6, 80'h0000_0000_0000_0000_0001, 40'h00_0000_0000, 8'd0, 1'b0, 2'd3, 32'h0},
    '{2'd3, 3'd1, 80'h0000_0000_0000_0000_0001, 40'h00_0000_0000, 8'd0, 1'b0, 2'd3, 32'h0}
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [2:0] req_count = 0;
  logic [79:0] req_addrs = 0;
  logic [39:0] req_data = 0;
  logic req_ready, done;
  logic [1:0] result;
  logic [39:0] rd_data;
  logic mb_valid, mb_we;
  logic [7:0] mb_addr;
  logic [31:0] mb_wdata;
  logic [31:0] mb_rdata;

  int tests = 0, fails = 0, cyc = 0;
  logic clr_cnt = 0;
  logic [7:0] cfg_busy = 0;
  logic cfg_err = 0;
  logic [7:0] busy_left;
  logic [31:0] cmd_seen;
  logic [31:0] wb [0:7];
  int n_cmd, n_wr, n_stat, n_rb, n_any, n_done;

  always #2 clk = ~clk;

  prw_seq #(.MAX_ITEMS(MAXI), .POLL_LIMIT(6), .POLL_GAP(3)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_count(req_count), .req_addrs(req_addrs), .req_data(req_data),
    .req_ready(req_ready), .done(done), .result(result), .rd_data(rd_data),
    .mb_valid(mb_valid), .mb_we(mb_we), .mb_addr(mb_addr),
    .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
  );

  always @(posedge clk) begin
    if (rst || clr_cnt) begin
      n_cmd <= 0; n_wr <= 0; n_stat <= 0; n_rb <= 0; n_any <= 0; n_done <= 0;
      cmd_seen <= 0; busy_left <= 0; mb_rdata <= 0;
      for (int k = 0; k < 8; k++) wb[k] <= 0;
    end else begin
      if (done) n_done <= n_done + 1;
      if (mb_valid) begin
        n_any <= n_any + 1;
        if (mb_we) begin
          if (mb_addr == 8'h00) begin
            cmd_seen <= mb_wdata; n_cmd <= n_cmd + 1; busy_left <= cfg_busy;
          end else if (mb_addr >= 8'h80 && mb_addr < 8'h90) begin
            wb[(mb_addr - 8'h80) >> 2] <= mb_wdata; n_wr <= n_wr + 1;
          end
        end else if (mb_addr == 8'h04) begin
          n_stat <= n_stat + 1;
          if (busy_left != 0) begin
            mb_rdata <= 32'h1; busy_left <= busy_left - 8'd1;
          end else begin
            mb_rdata <= {30'b0, cfg_err, 1'b0};
          end
        end else if (mb_addr == 8'h90) begin
          mb_rdata <= RB0; n_rb <= n_rb + 1;
        end else if (mb_addr == 8'h94) begin
          mb_rdata <= RB1; n_rb <= n_rb + 1;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [159:0] exp_pay(input logic [1:0] op, input int cnt,
                                           input logic [79:0] a, input logic [39:0] d);
    logic [159:0] r;
    r = '0;
    if (op == 2'd2) begin
      r[15:0] = a[15:0]; r[23:16] = d[7:0]; r[31:24] = d[15:8];
    end else begin
      for (int i = 0; i < cnt; i++) begin
        r[16*i +: 16] = a[16*i +: 16];
        if (op == 2'd0) r[8*(2*cnt + i) +: 8] = d[8*i +: 8];
      end
    end
    return r;
  endfunction

  task automatic run_vec(input vec_t v, input int num);
    int w, cnt, nwexp;
    string t;
    logic [159:0] pay;
    logic [39:0] rexp;
    cnt = int'(v.cnt);
    t = (v.op == 2'd0) ? "R3,R4" : (v.op == 2'd1) ? "R3,R5" : "R3,R6";
    @(negedge clk);
    clr_cnt = 1; cfg_busy = v.busy; cfg_err = v.err;
    req_op = v.op; req_count = v.cnt; req_addrs = v.adr; req_data = v.dat; req_valid = 1;
    @(negedge clk);
    clr_cnt = 0; req_valid = 0;
    w = 0;
    while (!done && w < 2000) begin @(negedge clk); w++; end
    chk(done, $sformatf("R12 vec%0d done seen", num), {63'b0, done}, 64'd1);
    chk(result == v.res, $sformatf("R8 R9 R10 R2 vec%0d result", num), 64'(result), 64'(v.res));
    rexp = '0;
    if (v.op == 2'd1 && v.res == 2'd0)
      for (int n = 0; n < cnt; n++) rexp[8*n +: 8] = {RB1, RB0}[8*n +: 8];
    chk(rd_data == rexp, $sformatf("R11 vec%0d rd_data", num), 64'(rd_data), 64'(rexp));
    if (v.res == 2'd3) begin
      chk(n_any == 0, $sformatf("R2 vec%0d no mailbox traffic", num), 64'(n_any), 64'd0);
    end else begin
      chk(n_cmd == 1 && cmd_seen == v.cmd, $sformatf("R7 vec%0d command word", num),
          64'(cmd_seen), 64'(v.cmd));
      nwexp = (v.op == 2'd2) ? 1 : (v.op == 2'd0) ? (3*cnt + 3) / 4 : (2*cnt + 3) / 4;
      chk(n_wr == nwexp, $sformatf("R7 vec%0d payload word count", num), 64'(n_wr), 64'(nwexp));
      pay = exp_pay(v.op, cnt, v.adr, v.dat);
      for (int j = 0; j < nwexp; j++)
        chk(wb[j] == pay[32*j +: 32], $sformatf("%s vec%0d payload word %0d", t, num, j),
            64'(wb[j]), 64'(pay[32*j +: 32]));
      if (v.res == 2'd2)
        chk(n_stat == 6, $sformatf("R10 vec%0d status reads", num), 64'(n_stat), 64'd6);
      else
        chk(n_stat == int'(v.busy) + 1, $sformatf("R8 vec%0d status reads", num),
            64'(n_stat), 64'(int'(v.busy) + 1));
      chk(n_rb == ((v.op == 2'd1 && v.res == 2'd0) ? (cnt + 3) / 4 : 0),
          $sformatf("R9 R11 vec%0d read-buffer reads", num), 64'(n_rb),
          64'((v.op == 2'd1 && v.res == 2'd0) ? (cnt + 3) / 4 : 0));
    end
    @(negedge clk);
    chk(!done, $sformatf("R12 vec%0d done one cycle", num), {63'b0, done}, 64'd0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !done && result == 2'd0 && rd_data == 0 && !mb_valid,
        "R1 reset state", {58'b0, req_ready, done, result, mb_valid, |rd_data}, 64'h20);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    @(negedge clk);
    clr_cnt = 1; cfg_busy = 8'd3; cfg_err = 0;
    req_op = 2'd0; req_count = 3'd1; req_addrs = 80'h77; req_data = 40'h5; req_valid = 1;
    @(negedge clk);
    clr_cnt = 0;
    chk(!req_ready, "R1 ready low while busy", {63'b0, req_ready}, 64'd0);
    req_op = 2'd1; req_count = 3'd2; req_addrs = 80'h0011_0022;
    repeat (3) @(negedge clk);
    req_valid = 0;
    w = 0;
    while (!done && w < 2000) begin @(negedge clk); w++; end
    repeat (20) @(negedge clk);
    chk(n_cmd == 1 && cmd_seen == 32'h000300FF, "R1 busy request ignored",
        64'(cmd_seen), 64'h000300FF);
    chk(n_done == 1, "R1 single done pulse", 64'(n_done), 64'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule